// File: doc/BRIEF.md
# Oversampled SPI Peripheral Receiver/Transmitter

This block is an SPI peripheral (slave) that lives entirely in the fast system clock domain. The SPI clock, the active-low select and the host-to-peripheral data line are never used as clocks. They arrive as ordinary pins. Each pin is registered through a synchroniser chain clocked by `clk`, and the block finds SPI clock edges by comparing the newest synchronised clock sample with the one before it.

Only mode 0 is supported. The block captures the data line on each detected rising edge of the SPI clock, most significant bit first. After eight rising edges inside one selection, it presents the byte on `rx_data` with a single-cycle `rx_valid` strobe. On the return path, a byte written with `tx_load` waits in a holding register. While the block is deselected, the shift register takes that byte, so its top bit is already on `miso` when the select falls. Each detected falling edge moves the next bit out. The falling edge that ends a byte reloads the holding register, so bytes can follow each other back to back.

The system clock must run well above three times the SPI clock, so that every SPI half-period is sampled several times.

Top module: `spi_os_periph`

## Requirements
- R1: After reset, `rx_valid` is 0, `rx_data` is 0 and `miso` is 0.
- R2: While `cs_n` is low, each SPI clock rising edge shifts `mosi` in MSB first. After the eighth such edge, `rx_data` holds the eight captured bits, with the first bit in bit 7.
- R3: `rx_valid` is high for exactly one `clk` cycle per completed byte.
- R4: If `sck` changes to high just after `clk` edge e, `rx_valid` is low after edges e+1 and e+2 and high after edge e+3 for the eighth bit of a byte.
- R5: While selected, `miso` shows bit 7 of the loaded byte before the first SPI rising edge. It advances one bit, MSB first, only on detected SPI falling edges.
- R6: The falling edge that completes a byte reloads the transmit shift register from the most recently loaded byte, so consecutive bytes need no gap.
- R7: Raising `cs_n` discards a partial byte. The next selection starts counting from bit 0 and raises no `rx_valid` for the discarded bits.
- R8: `miso` is 0 whenever the synchronised select is inactive.
- R9: SPI clock edges while `cs_n` is high cause no `rx_valid` and leave `rx_data` unchanged.
- R10: `tx_data` is captured only in a cycle where `tx_load` is 1. Otherwise changes on it have no effect on the bits sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples every SPI pin |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI clock pin, treated as data |
| cs_n | input | 1 | Active-low peripheral select pin |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller; 0 when deselected |
| rx_data | output | DATA_W | Last complete received byte |
| rx_valid | output | 1 | One-cycle strobe when `rx_data` updates |
| tx_data | input | DATA_W | Next byte to transmit |
| tx_load | input | 1 | Captures `tx_data` into the holding register |

## Verification
The assertions assume two things about the inputs. First, `sck` stays low whenever `cs_n` changes. Second, `sck` holds each level for many more `clk` cycles than the synchroniser depth, so no detected rising edge lands within eight cycles of the previous byte's strobe. The stimulus follows both: it toggles `sck` every four system cycles, changes `mosi` only while `sck` is low, and drops or raises `cs_n` only with `sck` low and a half-period of margin. `tx_load` is pulsed either while deselected or well away from the byte boundary.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;

    // Bundle of the three SPI pins that travel through the synchroniser together.
    typedef struct packed {
        logic sck;
        logic cs_n;
        logic mosi;
    } spi_pins_t;

    // Value the synchroniser holds in reset: clock low, deselected, data low.
    localparam spi_pins_t PINS_IDLE = '{sck: 1'b0, cs_n: 1'b1, mosi: 1'b0};

    // Edge events derived from two successive clock samples.
    typedef struct packed {
        logic rise;
        logic fall;
    } sck_edge_t;

    function automatic sck_edge_t find_edges(input logic now_s, input logic prev_s);
        sck_edge_t e;
        e.rise = now_s & ~prev_s;
        e.fall = ~now_s & prev_s;
        return e;
    endfunction

endpackage

// File: rtl/spi_os_sync.sv
module spi_os_sync
    import spi_os_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  spi_pins_t pin_i,
    output spi_pins_t sync_o
);

    spi_pins_t stage_q [SYNC_STAGES];

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= PINS_IDLE;
                    else     stage_q[g] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= PINS_IDLE;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/spi_os_edge.sv
module spi_os_edge
    import spi_os_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sck_s,
    output sck_edge_t edge_o
);

    logic sck_prev;

    always_ff @(posedge clk) begin
        if (rst) sck_prev <= 1'b0;
        else     sck_prev <= sck_s;
    end

    assign edge_o = find_edges(sck_s, sck_prev);

endmodule

// File: rtl/spi_os_rx.sv
module spi_os_rx #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              desel,
    input  logic              rise,
    input  logic              din,
    output logic [DATA_W-1:0] byte_o,
    output logic              byte_stb,
    output logic              at_boundary
);

    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] shifted;

    assign shifted = {shreg[DATA_W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_idx  <= '0;
            shreg    <= '0;
            byte_o   <= '0;
            byte_stb <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (desel) begin
                bit_idx <= '0;
            end else if (rise) begin
                shreg <= shifted;
                if (bit_idx == LAST_BIT) begin
                    bit_idx  <= '0;
                    byte_o   <= shifted;
                    byte_stb <= 1'b1;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

    assign at_boundary = (bit_idx == '0);

endmodule

// File: rtl/spi_os_tx.sv
module spi_os_tx #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              desel,
    input  logic              fall,
    input  logic              at_boundary,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              dout
);

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else if (load) hold_q <= load_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (desel) begin
            shreg <= hold_q;
        end else if (fall) begin
            if (at_boundary) shreg <= hold_q;
            else             shreg <= {shreg[DATA_W-2:0], 1'b0};
        end
    end

    assign dout = desel ? 1'b0 : shreg[DATA_W-1];

endmodule

// File: rtl/spi_os_periph.sv
module spi_os_periph
    import spi_os_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load
);

    spi_pins_t pins_raw;
    spi_pins_t pins_s;
    sck_edge_t sck_ev;
    logic      cs_sync;
    logic      sck_rise;
    logic      sck_fall;
    logic      byte_edge;

    assign pins_raw = '{sck: sck, cs_n: cs_n, mosi: mosi};

    spi_os_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pins_raw),
        .sync_o (pins_s)
    );

    spi_os_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sck_s  (pins_s.sck),
        .edge_o (sck_ev)
    );

    assign cs_sync  = pins_s.cs_n;
    assign sck_rise = sck_ev.rise;
    assign sck_fall = sck_ev.fall;

    spi_os_rx #(.DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .desel       (cs_sync),
        .rise        (sck_rise),
        .din         (pins_s.mosi),
        .byte_o      (rx_data),
        .byte_stb    (rx_valid),
        .at_boundary (byte_edge)
    );

    spi_os_tx #(.DATA_W(DATA_W)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .desel       (cs_sync),
        .fall        (sck_fall),
        .at_boundary (byte_edge),
        .load        (tx_load),
        .load_data   (tx_data),
        .dout        (miso)
    );

endmodule

// File: rtl/spi_os_periph_chk.sv
module spi_os_periph_chk #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic miso,
    input logic rx_valid,
    input logic cs_sync,
    input logic sck_rise,
    input logic sck_fall
);

    // Consecutive cycles the select pin has been sampled high, saturating.
    int unsigned hi_run;
    always_ff @(posedge clk) begin
        if (rst || !cs_n)            hi_run <= 0;
        else if (hi_run < SYNC_STAGES + 2) hi_run <= hi_run + 1;
    end

    // R3: strobe never lasts two cycles
    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R2: a strobe follows a rising edge seen while selected
    assert_strobe_after_rise_R2: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> ($past(sck_rise) && !$past(cs_sync)));

    // R9: no strobe from edges while deselected
    assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $past(cs_sync) |-> !rx_valid);

    // R8: once the select has been high through the synchroniser, miso rests at 0
    assert_idle_miso_R8: assert property (@(posedge clk) disable iff (rst)
        (hi_run > SYNC_STAGES) |-> (miso == 1'b0));

    // R5: miso moves only on a falling edge or a change of selection
    assert_miso_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (miso != $past(miso)) |-> ($past(sck_fall) || (cs_sync != $past(cs_sync))));

endmodule

bind spi_os_periph spi_os_periph_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .miso     (miso),
    .rx_valid (rx_valid),
    .cs_sync  (cs_sync),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
);

// File: tb/spi_os_periph_tb.sv
module spi_os_periph_tb;

    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       miso;
    logic [7:0] rx_data;
    logic       rx_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int n_valid = 0;
    logic [7:0] got_q [$];

    always #10 clk = ~clk;

    spi_os_periph u_dut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_load(tx_load)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h @%0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // Pin history: index 0 newest sample; the design acts on samples two and three edges old.
    logic h_sck [0:3];
    logic h_cs  [0:3];
    logic h_mo  [0:3];
    int         m_cnt;
    logic [7:0] m_rx, m_data, m_txsr, m_txhold;
    logic       m_valid;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                h_sck[i] = 1'b0; h_cs[i] = 1'b1; h_mo[i] = 1'b0;
            end
            m_cnt = 0; m_rx = 0; m_data = 0; m_valid = 0; m_txsr = 0; m_txhold = 0;
        end else begin
            for (int i = 3; i > 0; i--) begin
                h_sck[i] = h_sck[i-1]; h_cs[i] = h_cs[i-1]; h_mo[i] = h_mo[i-1];
            end
            h_sck[0] = sck; h_cs[0] = cs_n; h_mo[0] = mosi;
            m_valid = 1'b0;
            if (h_cs[2]) begin
                m_cnt = 0;
                m_txsr = m_txhold;
            end else if (h_sck[2] && !h_sck[3]) begin
                m_rx = {m_rx[6:0], h_mo[2]};
                if (m_cnt == 7) begin
                    m_data = m_rx; m_valid = 1'b1; m_cnt = 0;
                end else begin
                    m_cnt++;
                end
            end else if (!h_sck[2] && h_sck[3]) begin
                m_txsr = (m_cnt == 0) ? m_txhold : {m_txsr[6:0], 1'b0};
            end
            if (tx_load) m_txhold = tx_data;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            chk(rx_valid === m_valid, "R3", "model rx_valid", rx_valid, m_valid);
            chk(rx_data === m_data, "R2", "model rx_data", rx_data, m_data);
            chk(miso === (h_cs[1] ? 1'b0 : m_txsr[7]), "R5", "model miso",
                miso, h_cs[1] ? 1'b0 : m_txsr[7]);
            if (rx_valid) begin
                got_q.push_back(rx_data);
                n_valid++;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load_tx(input logic [7:0] b);
        tx_data = b; tx_load = 1'b1;
        tick(1);
        tx_load = 1'b0;
    endtask

    task automatic select_on();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic select_off();
        tick(HALF);
        cs_n = 1'b1;
        tick(3 * HALF);
    endtask

    task automatic send_bits(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
        mi = 8'h00;
        for (int b = 7; b > 7 - nbits; b--) begin
            mosi = mo[b];
            tick(HALF);
            mi[b] = miso;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    bit done = 0;

    initial begin
        logic [7:0] mi, mi2;
        int base;

        tick(5);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(rx_valid === 1'b0, "R1", "rx_valid after reset", rx_valid, 0);
        chk(rx_data === 8'h00, "R1", "rx_data after reset", rx_data, 0);
        chk(miso === 1'b0, "R1", "miso after reset", miso, 0);
        tick(4);

        // Single byte each way
        load_tx(8'h3C);
        tick(2);
        select_on();
        send_bits(8'hA5, 8, mi);
        select_off();
        chk(got_q.size() == 1, "R2", "bytes after first transfer", got_q.size(), 1);
        if (got_q.size() > 0) chk(got_q[0] === 8'hA5, "R2", "first byte", got_q[0], 8'hA5);
        chk(mi === 8'h3C, "R5", "miso bits of first byte", mi, 8'h3C);

        // Back-to-back bytes with reload of the transmit byte
        load_tx(8'hC3);
        tick(2);
        select_on();
        load_tx(8'h81);
        base = n_valid;
        send_bits(8'hFF, 8, mi);
        send_bits(8'h00, 8, mi2);
        select_off();
        chk(mi === 8'hC3, "R6", "first of two tx bytes", mi, 8'hC3);
        chk(mi2 === 8'h81, "R6", "reloaded tx byte", mi2, 8'h81);
        chk(n_valid - base == 2, "R3", "strobes for two bytes", n_valid - base, 2);
        if (got_q.size() >= 3) begin
            chk(got_q[1] === 8'hFF, "R2", "byte 0xFF", got_q[1], 8'hFF);
            chk(got_q[2] === 8'h00, "R2", "byte 0x00", got_q[2], 8'h00);
        end else chk(0, "R2", "byte count after pair", got_q.size(), 3);

        // R7: partial byte discarded, counter restarts
        base = n_valid;
        select_on();
        send_bits(8'hE0, 3, mi);
        select_off();
        chk(n_valid == base, "R7", "no strobe for partial byte", n_valid - base, 0);
        select_on();
        send_bits(8'h5A, 8, mi);
        select_off();
        chk(n_valid - base == 1, "R7", "one strobe after restart", n_valid - base, 1);
        chk(rx_data === 8'h5A, "R7", "byte after restart", rx_data, 8'h5A);

        // R9 and R8: clock activity while deselected
        base = n_valid;
        mosi = 1'b1;
        for (int k = 0; k < 8; k++) begin
            tick(HALF); sck = 1'b1;
            tick(HALF); sck = 1'b0;
            chk(miso === 1'b0, "R8", "miso while deselected", miso, 0);
        end
        tick(3 * HALF);
        mosi = 1'b0;
        chk(n_valid == base, "R9", "no strobe while deselected", n_valid - base, 0);
        chk(rx_data === 8'h5A, "R9", "rx_data held while deselected", rx_data, 8'h5A);

        // R10: tx_data without tx_load is ignored
        tx_data = 8'hEE;
        tick(4);
        select_on();
        send_bits(8'h11, 8, mi);
        select_off();
        chk(mi === 8'h81, "R10", "unloaded tx_data ignored", mi, 8'h81);

        // R4: strobe timing relative to the eighth rising clock pin edge
        select_on();
        send_bits(8'h96, 7, mi);
        mosi = 1'b0;
        tick(HALF);
        sck = 1'b1;           // driven just after edge e
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(rx_valid === 1'b0, "R4", "no strobe after e+2", rx_valid, 0);
        @(negedge clk);
        chk(rx_valid === 1'b1, "R4", "strobe after e+3", rx_valid, 1);
        chk(rx_data === 8'h96, "R4", "byte with timed strobe", rx_data, 8'h96);
        @(posedge clk); #1;
        tick(HALF);
        sck = 1'b0;
        select_off();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule